// File: doc/BRIEF.md
# Audio Playback Sample Queue with DMA Request

This block sits on the transmit side of an audio DAC interface. A processor or DMA engine stores samples into a 64-entry queue through a small 32-bit register file. The queue raises a DMA request while it has enough free space. The request has hysteresis: it is set at one free-space level and dropped at a lower one.

On every pulse of the sample tick strobe the block hands one left/right pair to the DAC, widened to 24 bits.

- **Stereo mode:** the queue holds left and right samples alternately.
- **Mono mode:** each stored sample is sent to both channels.
- **Input width:** 16-bit input is widened either with zero low bits or with copies of the sample's MSB. 24-bit input is taken from the top of a 32-bit write.
- **Underrun:** when the queue cannot supply a full pair, the DAC gets either zeros or the previous pair again, and a sticky flag records the event.
- **Pass-through:** the sample-rate code and filter-length select are passed straight out to the DAC timing logic.

Top module: `audio_tx_fifo`

## Requirements
- R1: Register map. Control is at byte offset 0x04, status at 0x08 and the data write port at 0x0C. Reads of any other offset return 0.
  - Status layout: bit 0 is the empty flag, bit 1 the sticky underrun flag, bit 2 the sticky overflow flag, and bits 23:8 the free-entry count.
  - After reset the control register is 0 and status reads 0x00004001 (64 free, empty).
- R2: A data write is widened to 24 bits when it is accepted.
  - Control bit 5 = 1 (24-bit input): the word is write bits 31:8.
  - Control bit 5 = 0 (16-bit input): write bits 15:0 fill the top 16 bits. The low 8 bits are zero when control bit 24 = 0, and copies of bit 15 when control bit 24 = 1.
- R3: Channel mapping.
  - Stereo (control bit 6 = 0): a tick consumes two entries. The older entry goes to the left output and the newer to the right.
  - Mono (control bit 6 = 1): a tick consumes one entry and drives it on both outputs.
- R4: Underrun.
  - A tick with fewer entries than the mode needs consumes nothing and sets status bit 1.
  - It outputs zeros when control bit 26 = 0, or repeats the previous pair when control bit 26 = 1.
  - Writing 1 to status bit 1 clears the flag.
- R5: A data write while 64 entries are held is dropped. The held entries are kept unchanged, and status bit 2 is set. Writing 1 to status bit 2 clears it.
- R6: Writing control bit 0 = 1 empties the queue on the next cycle. Bit 0 then reads back as 0.
- R7: DMA request hysteresis.
  - The request is set when the free count is at or above the trigger level in control bits 13:8.
  - Otherwise it is cleared when the free count is below 2, 4, 8 or 16 for control bits 22:21 = 0, 1, 2 or 3.
  - Otherwise it holds its value.
  - The request follows the free count one cycle after the count changes.
- R8: With control bit 4 = 0 the DMA request is low.
- R9: Control bits 31:29 appear on `rate_code` and control bit 28 on `short_filter`.
- R10: `dac_valid` is high for exactly the cycle after each tick cycle, and `dac_left`/`dac_right` change only with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sample_tick | input | 1 | One-cycle strobe requesting a DAC pair |
| dac_left | output | 24 | Left channel word |
| dac_right | output | 24 | Right channel word |
| dac_valid | output | 1 | Pulse marking a new pair |
| dma_req | output | 1 | DMA request, level |
| rate_code | output | 3 | Sample-rate code to DAC timing |
| short_filter | output | 1 | Short filter select |

## Verification
The checker watches on every cycle that:
- the fill count never exceeds the depth and a pending flush always leaves the queue empty;
- `dac_valid` tracks the tick one cycle later;
- the DMA request never rises without the set condition, never falls while both enabled and above the clear threshold, and is never high when the enable was off in the cycle before.

The expansion values, the left/right ordering, the two underrun policies, the dropped write on a full queue and the exact free levels where the request turns on and off are data-dependent. Only the bench's scenarios can show those.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    localparam int REG_W     = 32;
    localparam int OFS_CTRL  = 4;
    localparam int OFS_STAT  = 8;
    localparam int OFS_DATA  = 12;

    typedef struct packed {
        logic [2:0] rate;
        logic       short_fir;
        logic       hold_last;
        logic       msb_fill;
        logic [1:0] clr_sel;
        logic [5:0] trig;
        logic       mono;
        logic       wide;
        logic       dreq_en;
        logic       flush;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[31:29] = c.rate;
        w[28]    = c.short_fir;
        w[26]    = c.hold_last;
        w[24]    = c.msb_fill;
        w[22:21] = c.clr_sel;
        w[13:8]  = c.trig;
        w[6]     = c.mono;
        w[5]     = c.wide;
        w[4]     = c.dreq_en;
        w[0]     = c.flush;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.rate      = w[31:29];
        c.short_fir = w[28];
        c.hold_last = w[26];
        c.msb_fill  = w[24];
        c.clr_sel   = w[22:21];
        c.trig      = w[13:8];
        c.mono      = w[6];
        c.wide      = w[5];
        c.dreq_en   = w[4];
        c.flush     = w[0];
        return c;
    endfunction

endpackage

// File: rtl/audio_tx_fmt.sv
module audio_tx_fmt #(
    parameter int DW       = 32,
    parameter int DAC_W    = 24,
    parameter int NARROW_W = 16
) (
    input  logic [DW-1:0]    wdata,
    input  logic             wide,
    input  logic             msb_fill,
    output logic [DAC_W-1:0] sample
);
    localparam int PAD_W = DAC_W - NARROW_W;

    logic [PAD_W-1:0] pad;

    always_comb begin
        pad = msb_fill ? {PAD_W{wdata[NARROW_W-1]}} : '0;
        if (wide) begin
            sample = wdata[DW-1 -: DAC_W];
        end else begin
            sample = {wdata[NARROW_W-1:0], pad};
        end
    end
endmodule

// File: rtl/audio_tx_store.sv
module audio_tx_store #(
    parameter int DEPTH = 64,
    parameter int W     = 24,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [PTR_W-1:0] raddr_a,
    input  logic [PTR_W-1:0] raddr_b,
    output logic [W-1:0]     rdata_a,
    output logic [W-1:0]     rdata_b
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/audio_tx_dreq.sv
module audio_tx_dreq #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] free,
    input  logic [5:0]       trig,
    input  logic [1:0]       clr_sel,
    output logic             req
);
    logic             req_d, req_q;
    logic [CNT_W-1:0] thr;

    always_comb begin
        thr   = CNT_W'(2) << clr_sel;
        req_d = req_q;
        if (!en) begin
            req_d = 1'b0;
        end else if (free >= CNT_W'(trig)) begin
            req_d = 1'b1;
        end else if (free < thr) begin
            req_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req = req_q;
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import audio_tx_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6,
    parameter int DAC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              sample_tick,
    output logic [DAC_W-1:0]  dac_left,
    output logic [DAC_W-1:0]  dac_right,
    output logic              dac_valid,
    output logic              dma_req,
    output logic [2:0]        rate_code,
    output logic              short_filter
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             udr;
        logic             ovf;
        logic [DAC_W-1:0] left;
        logic [DAC_W-1:0] right;
        logic             valid;
    } state_t;

    state_t s_d, s_q;

    logic             sel_ctrl, sel_stat, sel_data;
    logic             push, pop;
    logic [1:0]       need;
    logic [DAC_W-1:0] in_word, rd_a, rd_b;
    logic [CNT_W-1:0] fill_cnt, free_cnt;
    logic             flush_pend, ctrl_dreq_en;

    assign fill_cnt     = s_q.count;
    assign free_cnt     = CNT_W'(DEPTH) - fill_cnt;
    assign flush_pend   = s_q.ctrl.flush;
    assign ctrl_dreq_en = s_q.ctrl.dreq_en;

    audio_tx_fmt #(.DW(REG_W), .DAC_W(DAC_W), .NARROW_W(16)) u_fmt (
        .wdata    (bus_wdata),
        .wide     (s_q.ctrl.wide),
        .msb_fill (s_q.ctrl.msb_fill),
        .sample   (in_word)
    );

    audio_tx_store #(.DEPTH(DEPTH), .W(DAC_W)) u_store (
        .clk     (clk),
        .we      (push),
        .waddr   (s_q.wr_ptr),
        .wdata   (in_word),
        .raddr_a (s_q.rd_ptr),
        .raddr_b (s_q.rd_ptr + PTR_W'(1)),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    audio_tx_dreq #(.CNT_W(CNT_W)) u_dreq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl_dreq_en),
        .free    (free_cnt),
        .trig    (s_q.ctrl.trig),
        .clr_sel (s_q.ctrl.clr_sel),
        .req     (dma_req)
    );

    always_comb begin
        sel_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        sel_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
        sel_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
        need     = s_q.ctrl.mono ? 2'd1 : 2'd2;
        pop      = sample_tick && !flush_pend && (fill_cnt >= CNT_W'(need));
        push     = sel_data && !flush_pend && (fill_cnt < CNT_W'(DEPTH));

        s_d       = s_q;
        s_d.valid = sample_tick;

        // sticky flags: clear first so a same-cycle event wins
        if (sel_stat && bus_wdata[1]) s_d.udr = 1'b0;
        if (sel_stat && bus_wdata[2]) s_d.ovf = 1'b0;
        if (sel_data && (fill_cnt == CNT_W'(DEPTH))) s_d.ovf = 1'b1;

        if (sample_tick) begin
            if (pop) begin
                s_d.left   = rd_a;
                s_d.right  = s_q.ctrl.mono ? rd_a : rd_b;
                s_d.rd_ptr = s_q.rd_ptr + PTR_W'(need);
            end else begin
                s_d.udr = 1'b1;
                if (!s_q.ctrl.hold_last) begin
                    s_d.left  = '0;
                    s_d.right = '0;
                end
            end
        end

        if (push) s_d.wr_ptr = s_q.wr_ptr + PTR_W'(1);
        s_d.count = fill_cnt + CNT_W'(push) - (pop ? CNT_W'(need) : CNT_W'(0));

        if (flush_pend) begin
            s_d.wr_ptr     = '0;
            s_d.rd_ptr     = '0;
            s_d.count      = '0;
            s_d.ctrl.flush = 1'b0;
        end

        if (sel_ctrl) s_d.ctrl = ctrl_unpack(bus_wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata = ctrl_pack(s_q.ctrl);
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[23:8] = 16'(free_cnt);
            bus_rdata[2]    = s_q.ovf;
            bus_rdata[1]    = s_q.udr;
            bus_rdata[0]    = (fill_cnt == '0);
        end
    end

    assign dac_left     = s_q.left;
    assign dac_right    = s_q.right;
    assign dac_valid    = s_q.valid;
    assign rate_code    = s_q.ctrl.rate;
    assign short_filter = s_q.ctrl.short_fir;
endmodule

// File: rtl/audio_tx_chk.sv
module audio_tx_chk #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic             dac_valid,
    input logic             dma_req,
    input logic             dma_en,
    input logic             flush_pend,
    input logic [CNT_W-1:0] count,
    input logic [5:0]       trig,
    input logic [1:0]       clr_sel
);
    logic [CNT_W-1:0] free;
    logic [CNT_W-1:0] thr;
    assign free = CNT_W'(DEPTH) - count;
    assign thr  = CNT_W'(2) << clr_sel;

    // R5: the queue never holds more than its depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R6: a pending flush leaves the queue empty and clears itself
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend |=> (count == '0) && !flush_pend);

    // R10: a pair is presented exactly one cycle after each tick
    a_r10_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> dac_valid);
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> !dac_valid);

    // R8: the request is only high when enabled the cycle before
    a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !dma_req);

    // R7: the request rises only at or above the trigger level
    a_r7_rise_at_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && dma_en && free < CNT_W'(trig)) |=> !dma_req);

    // R7: an enabled request falls only below the clear threshold
    a_r7_fall_below_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_en && free >= thr) |=> dma_req);
endmodule

bind audio_tx_fifo audio_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .dac_valid   (dac_valid),
    .dma_req     (dma_req),
    .dma_en      (ctrl_dreq_en),
    .flush_pend  (flush_pend),
    .count       (fill_cnt),
    .trig        (s_q.ctrl.trig),
    .clr_sel     (s_q.ctrl.clr_sel)
);

// File: tb/tb_audio_tx_fifo.sv
module tb_audio_tx_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sample_tick = 1'b0;
    logic [23:0] dac_left, dac_right;
    logic        dac_valid, dma_req, short_filter;
    logic [2:0]  rate_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [5:0] A_CTRL = 6'h04;
    localparam logic [5:0] A_STAT = 6'h08;
    localparam logic [5:0] A_DATA = 6'h0C;

    // {control, data word, expected 24-bit output}, mono so both channels match
    localparam logic [87:0] VEC [6] = '{
        {32'h0000_0040, 32'h0000_8001, 24'h800100},
        {32'h0100_0040, 32'h0000_8001, 24'h8001FF},
        {32'h0100_0040, 32'h0000_7FFE, 24'h7FFE00},
        {32'h0000_0060, 32'h1234_5678, 24'h123456},
        {32'h0100_0060, 32'hABCD_EF01, 24'hABCDEF},
        {32'h0000_0040, 32'hFFFF_1234, 24'h123400}
    };

    audio_tx_fifo dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_tick(sample_tick),
        .dac_left(dac_left), .dac_right(dac_right), .dac_valid(dac_valid),
        .dma_req(dma_req), .rate_code(rate_code), .short_filter(short_filter)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic setup(input logic [31:0] c);
        wr(A_CTRL, c | 32'h1);
        @(negedge clk);
        wr(A_STAT, 32'h6);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, r);  check("R1 reset status", r, 32'h0000_4001);
        rd(A_CTRL, r);  check("R1 reset control", r, 32'h0);
        rd(6'h10, r);   check("R1 unmapped read", r, 32'h0);
        check("R8 reset dma_req", {31'b0, dma_req}, 32'h0);
        check("R10 reset valid", {31'b0, dac_valid}, 32'h0);

        // R2 expansion table
        for (int i = 0; i < 6; i++) begin
            setup(VEC[i][87:56]);
            wr(A_DATA, VEC[i][55:24]);
            tick();
            check("R2 left", {8'b0, dac_left}, {8'b0, VEC[i][23:0]});
            check("R3 mono right", {8'b0, dac_right}, {8'b0, VEC[i][23:0]});
            check("R10 valid", {31'b0, dac_valid}, 32'h1);
        end

        // R3 stereo ordering
        setup(32'h0);
        wr(A_DATA, 32'h1111); wr(A_DATA, 32'h2222);
        tick();
        check("R3 stereo left", {8'b0, dac_left}, 32'h0011_1100);
        check("R3 stereo right", {8'b0, dac_right}, 32'h0022_2200);
        @(negedge clk);
        check("R10 valid one cycle", {31'b0, dac_valid}, 32'h0);

        // R3 mono consumes one entry
        setup(32'h40);
        wr(A_DATA, 32'h1); wr(A_DATA, 32'h2);
        tick();
        rd(A_STAT, r); check("R3 mono one entry", r, 32'h0000_3F00);

        // R4 zero policy
        setup(32'h0);
        wr(A_DATA, 32'h0A00); wr(A_DATA, 32'h0B00);
        tick(); tick();
        check("R4 zero left", {8'b0, dac_left}, 32'h0);
        check("R4 zero right", {8'b0, dac_right}, 32'h0);
        rd(A_STAT, r); check("R4 underrun flag", r, 32'h0000_4003);
        wr(A_STAT, 32'h2);
        rd(A_STAT, r); check("R4 underrun cleared", r, 32'h0000_4001);

        // R4 partial stereo pair is an underrun and is kept
        setup(32'h0);
        wr(A_DATA, 32'h0C00);
        tick();
        rd(A_STAT, r); check("R4 partial pair kept", r, 32'h0000_3F02);

        // R4 repeat policy
        setup(32'h0400_0000);
        wr(A_DATA, 32'h0A00); wr(A_DATA, 32'h0B00);
        tick(); tick();
        check("R4 repeat left", {8'b0, dac_left}, 32'h000A_0000);
        check("R4 repeat right", {8'b0, dac_right}, 32'h000B_0000);

        // R5 overflow
        setup(32'h0);
        for (int i = 0; i < 65; i++) wr(A_DATA, 32'h0100 + i);
        rd(A_STAT, r); check("R5 full and overflow", r, 32'h0000_0004);
        tick();
        check("R5 oldest left kept", {8'b0, dac_left}, 32'h0001_0000);
        check("R5 next right kept", {8'b0, dac_right}, 32'h0001_0100);
        wr(A_STAT, 32'h4);
        rd(A_STAT, r); check("R5 overflow cleared", r, 32'h0000_0200);

        // R6 flush
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        rd(A_CTRL, r); check("R6 flush self clears", r, 32'h0);
        rd(A_STAT, r); check("R6 flush empties", r & 32'h00FF_FF01, 32'h0000_4001);

        // R7 hysteresis: trigger 32, clear below 4
        setup(32'h0020_2010);
        @(negedge clk); @(negedge clk);
        check("R7 set when empty", {31'b0, dma_req}, 32'h1);
        for (int i = 0; i < 60; i++) wr(A_DATA, 32'h0);
        @(negedge clk);
        check("R7 hold at free 4", {31'b0, dma_req}, 32'h1);
        wr(A_DATA, 32'h0);
        @(negedge clk);
        check("R7 clear at free 3", {31'b0, dma_req}, 32'h0);
        for (int i = 0; i < 14; i++) tick();
        @(negedge clk);
        check("R7 hold low at free 31", {31'b0, dma_req}, 32'h0);
        tick();
        @(negedge clk);
        check("R7 set at free 33", {31'b0, dma_req}, 32'h1);

        // R8 enable off
        wr(A_CTRL, 32'h0020_2000);
        @(negedge clk);
        check("R8 disabled", {31'b0, dma_req}, 32'h0);

        // R9 pass-through
        wr(A_CTRL, 32'hB000_0000);
        check("R9 rate code", {29'b0, rate_code}, 32'h5);
        check("R9 short filter", {31'b0, short_filter}, 32'h1);
        rd(A_CTRL, r); check("R9 control readback", r, 32'hB000_0000);

        finish_run();
    end
endmodule